// File: doc/BRIEF.md
# Triggered Waveform Update Controller

This block times the playback of a stored waveform for a two-channel analog output stage. Once armed by a software start, it waits for a trigger edge. It may then wait a programmed start delay. After that it issues one update strobe per programmed interval, and with each strobe it presents the buffer index of the sample being played. A pass over the stored waveform can be repeated a programmed number of times, or without end. A programmed gap may be placed between passes.

A software stop ends playback in one of three ways: at once, at the end of the current pass, or at the end of the current block of passes. With re-trigger enabled, a finished generation goes back to waiting for the next trigger instead of going idle.

The clock is the timebase: every interval, delay and gap is counted in clock cycles. All outputs are plain control pins; there is no data stream, so no handshake is involved.

Top module: `wave_update_ctrl`

## Requirements
- R1: After reset `busy` is 0, `upd_strobe` is 0 and `rd_addr` is 0.
- R2: A `sw_start` pulse while idle raises `busy` and arms the block. Strobes begin only after a rising edge of `trig` seen while armed. A trigger edge while idle is ignored, and an armed block without a trigger produces no strobe.
- R3: While running, consecutive strobes within a pass are exactly max(`cfg_interval`, MIN_INTERVAL = 40) cycles apart.
- R4: A nonzero `cfg_start_dly` of D cycles makes the first strobe come exactly D cycles later than with a zero start delay.
- R5: Strobes present `rd_addr` = 0, 1, …, L-1 in order, and `wave_end` is 1 exactly with the strobe at L-1. L is `cfg_wave_len`, with 0 read as 1, capped at 2048 when `cfg_dual` = 0 and at 1024 when `cfg_dual` = 1.
- R6: With `cfg_infinite` = 0, generation ends after `cfg_iter` passes (0 read as 1). Without re-trigger, `busy` then drops to 0.
- R7: A nonzero `cfg_gap` of G cycles makes the spacing between the last strobe of one pass and the first strobe of the next equal to interval + G. With G = 0 that spacing is the plain interval.
- R8: With `cfg_infinite` = 1, passes continue beyond `cfg_iter` until a stop.
- R9: With `cfg_retrig` = 1, a finished generation returns to the armed state with `busy` still 1, and the next trigger edge replays from address 0. Trigger edges that arrive while a generation runs are ignored.
- R10: `cfg_stop_mode` = 0 (or 3): after `sw_stop` is sampled, no further strobe occurs from the following cycle on, and `busy` is 0 within two cycles.
- R11: `cfg_stop_mode` = 1: after `sw_stop`, strobes continue until the one at address L-1, then the block goes idle.
- R12: `cfg_stop_mode` = 2: after `sw_stop`, strobes continue until the current block of `cfg_iter` passes is complete, then the block goes idle.
- R13: `sw_stop` while armed or while waiting out the start delay returns the block to idle with no strobe, in any stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Trigger, rising edge active (synchronized inside) |
| sw_start | input | 1 | Software start pulse (arms the block) |
| sw_stop | input | 1 | Software stop pulse |
| cfg_interval | input | 24 | Update interval in cycles (raised to 40 if below) |
| cfg_start_dly | input | 16 | Trigger-to-start delay in cycles, 0 = none |
| cfg_gap | input | 16 | Gap between passes in cycles, 0 = back-to-back |
| cfg_iter | input | 16 | Passes per block, 0 read as 1 |
| cfg_infinite | input | 1 | 1 = repeat blocks until stopped |
| cfg_stop_mode | input | 2 | 0/3 immediate, 1 end of pass, 2 end of block |
| cfg_retrig | input | 1 | 1 = re-arm after a finished generation |
| cfg_wave_len | input | 12 | Samples per pass |
| cfg_dual | input | 1 | 1 = both channels in use, length capped at half depth |
| upd_strobe | output | 1 | One-cycle update strobe; also advances the buffer read |
| rd_addr | output | 11 | Buffer index of the sample played by the current strobe |
| wave_end | output | 1 | With the strobe of the last sample of a pass |
| busy | output | 1 | High from start until the block returns to idle |

## Verification
Finite playback with a constant interval is compared against runs with a short interval that must be raised to the minimum, a start delay, and an inter-pass gap. Each of those shifts a single measured distance (first-strobe latency, or the smallest and largest strobe spacing), so a wrong count in one timer stands apart from the others. The three stop modes are each issued mid-pass on an endless run, and the strobe totals they leave behind (5, 8, 6) separate an immediate halt from pass-end and block-end completion. Re-trigger runs send a trigger during playback and then a second trigger after completion, which tells an ignored trigger from a restart. Idle and armed-without-trigger cases show that strobes need both start and trigger.

// File: rtl/wfu_pkg.sv
`timescale 1ns/1ps
package wfu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DLY,
    ST_RUN,
    ST_GAP
  } wfu_state_e;

  localparam logic [1:0] STOP_NOW   = 2'd0;
  localparam logic [1:0] STOP_PASS  = 2'd1;
  localparam logic [1:0] STOP_BLOCK = 2'd2;
endpackage

// File: rtl/wfu_trig_edge.sv
`timescale 1ns/1ps
module wfu_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= trig_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], trig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wfu_timer.sv
`timescale 1ns/1ps
module wfu_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  // load: expires val cycles later; while running it reloads itself on expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= val - 1'b1;
    else if (run) begin
      if (cnt_q == '0) cnt_q <= val - 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wfu_seq.sv
`timescale 1ns/1ps
module wfu_seq
  import wfu_pkg::*;
#(
  parameter int AW     = 11,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_rise,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              dly_nz,
  input  logic              gap_nz,
  input  logic [ITER_W-1:0] cfg_iter,
  input  logic              cfg_infinite,
  input  logic [1:0]        cfg_stop_mode,
  input  logic              cfg_retrig,
  input  logic [AW:0]       last_idx,
  input  logic              ui_zero,
  input  logic              dly_zero,
  input  logic              gap_zero,
  output logic              ui_load,
  output logic              ui_run,
  output logic              dly_load,
  output logic              dly_run,
  output logic              gap_load,
  output logic              gap_run,
  output logic              fire,
  output logic              pass_end,
  output logic [AW-1:0]     sidx,
  output logic              busy
);
  wfu_state_e        st_q, st_nxt;
  logic [ITER_W-1:0] it_q;
  logic              stop_q;
  logic              stop_now, last_samp, iter_last, finish;

  assign stop_now  = (cfg_stop_mode == STOP_NOW) || (cfg_stop_mode == 2'd3);
  assign last_samp = ({1'b0, sidx} == last_idx);
  assign iter_last = (cfg_iter == '0) ? (it_q == '0) : (it_q == cfg_iter - 1'b1);

  assign fire     = (st_q == ST_RUN) && ui_zero && !(stop_q && stop_now);
  assign pass_end = fire && last_samp;

  assign finish = (stop_q && cfg_stop_mode == STOP_PASS)
               || (stop_q && cfg_stop_mode == STOP_BLOCK && iter_last)
               || (!cfg_infinite && iter_last);

  assign ui_run  = (st_q == ST_RUN);
  assign dly_run = (st_q == ST_DLY);
  assign gap_run = (st_q == ST_GAP);
  assign busy    = (st_q != ST_IDLE);

  always_comb begin
    st_nxt   = st_q;
    ui_load  = 1'b0;
    dly_load = 1'b0;
    gap_load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (sw_start) st_nxt = ST_ARM;
      ST_ARM: begin
        if (stop_q) st_nxt = ST_IDLE;
        else if (trig_rise) begin
          if (dly_nz) begin st_nxt = ST_DLY; dly_load = 1'b1; end
          else        begin st_nxt = ST_RUN; ui_load  = 1'b1; end
        end
      end
      ST_DLY: begin
        if (stop_q)        st_nxt = ST_IDLE;
        else if (dly_zero) begin st_nxt = ST_RUN; ui_load = 1'b1; end
      end
      ST_RUN: begin
        if (stop_q && stop_now) st_nxt = ST_IDLE;
        else if (pass_end) begin
          if (finish)      st_nxt = (cfg_retrig && !stop_q) ? ST_ARM : ST_IDLE;
          else if (gap_nz) begin st_nxt = ST_GAP; gap_load = 1'b1; end
        end
      end
      ST_GAP: begin
        if (stop_q && cfg_stop_mode != STOP_BLOCK) st_nxt = ST_IDLE;
        else if (gap_zero) begin st_nxt = ST_RUN; ui_load = 1'b1; end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sidx   <= '0;
      it_q   <= '0;
      stop_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (st_nxt == ST_IDLE)            stop_q <= 1'b0;
      else if (sw_stop && st_q != ST_IDLE) stop_q <= 1'b1;
      if (st_q == ST_IDLE && sw_start) begin
        sidx <= '0;
        it_q <= '0;
      end else if (fire) begin
        sidx <= last_samp ? '0 : sidx + 1'b1;
        if (last_samp) it_q <= iter_last ? '0 : it_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wave_update_ctrl.sv
`timescale 1ns/1ps
module wave_update_ctrl #(
  parameter  int DEPTH        = 2048,
  parameter  int IV_W         = 24,
  parameter  int DLY_W        = 16,
  parameter  int ITER_W       = 16,
  parameter  int MIN_INTERVAL = 40,
  parameter  int TRIG_SYNC    = 2,
  localparam int AW           = $clog2(DEPTH),
  localparam int LEN_W        = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic [IV_W-1:0]   cfg_interval,
  input  logic [DLY_W-1:0]  cfg_start_dly,
  input  logic [DLY_W-1:0]  cfg_gap,
  input  logic [ITER_W-1:0] cfg_iter,
  input  logic              cfg_infinite,
  input  logic [1:0]        cfg_stop_mode,
  input  logic              cfg_retrig,
  input  logic [LEN_W-1:0]  cfg_wave_len,
  input  logic              cfg_dual,
  output logic              upd_strobe,
  output logic [AW-1:0]     rd_addr,
  output logic              wave_end,
  output logic              busy
);
  localparam logic [IV_W-1:0]  MIN_IV   = IV_W'(MIN_INTERVAL);
  localparam logic [LEN_W-1:0] CAP_ONE  = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] CAP_DUAL = LEN_W'(DEPTH / 2);

  logic              trig_rise;
  logic [IV_W-1:0]   ui_val;
  logic [LEN_W-1:0]  len_cap, eff_len, last_idx;
  logic ui_load, ui_run, ui_zero;
  logic dly_load, dly_run, dly_zero;
  logic gap_load, gap_run, gap_zero;

  assign ui_val  = (cfg_interval < MIN_IV) ? MIN_IV : cfg_interval;
  assign len_cap = cfg_dual ? CAP_DUAL : CAP_ONE;

  always_comb begin
    if (cfg_wave_len == '0)          eff_len = LEN_W'(1);
    else if (cfg_wave_len > len_cap) eff_len = len_cap;
    else                             eff_len = cfg_wave_len;
  end
  assign last_idx = eff_len - 1'b1;

  wfu_trig_edge #(.STAGES(TRIG_SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .rise(trig_rise)
  );

  wfu_timer #(.W(IV_W)) u_ui_tmr (
    .clk(clk), .rst_n(rst_n), .load(ui_load), .run(ui_run),
    .val(ui_val), .zero(ui_zero)
  );

  wfu_timer #(.W(DLY_W)) u_dly_tmr (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .run(dly_run),
    .val(cfg_start_dly), .zero(dly_zero)
  );

  wfu_timer #(.W(DLY_W)) u_gap_tmr (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .run(gap_run),
    .val(cfg_gap), .zero(gap_zero)
  );

  wfu_seq #(.AW(AW), .ITER_W(ITER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise),
    .sw_start(sw_start), .sw_stop(sw_stop),
    .dly_nz(cfg_start_dly != '0), .gap_nz(cfg_gap != '0),
    .cfg_iter(cfg_iter), .cfg_infinite(cfg_infinite),
    .cfg_stop_mode(cfg_stop_mode), .cfg_retrig(cfg_retrig),
    .last_idx(last_idx),
    .ui_zero(ui_zero), .dly_zero(dly_zero), .gap_zero(gap_zero),
    .ui_load(ui_load), .ui_run(ui_run),
    .dly_load(dly_load), .dly_run(dly_run),
    .gap_load(gap_load), .gap_run(gap_run),
    .fire(upd_strobe), .pass_end(wave_end),
    .sidx(rd_addr), .busy(busy)
  );
endmodule

// File: rtl/wave_update_ctrl_chk.sv
`timescale 1ns/1ps
module wave_update_ctrl_chk #(
  parameter int DEPTH        = 2048,
  parameter int MIN_INTERVAL = 40
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sw_stop,
  input logic [1:0]               cfg_stop_mode,
  input logic                     upd_strobe,
  input logic [$clog2(DEPTH)-1:0] rd_addr,
  input logic                     wave_end,
  input logic                     busy
);
  logic [31:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (upd_strobe) begin
      since_q <= 32'd1;
      seen_q  <= 1'b1;
    end else if (since_q != 32'hFFFF_FFFF) begin
      since_q <= since_q + 32'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !upd_strobe);

  // R3
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && seen_q) |-> (since_q >= MIN_INTERVAL));

  // R5
  end_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_end |-> upd_strobe);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !wave_end) |=> (rd_addr == $past(rd_addr) + 1'b1));

  // R5
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_end |=> (rd_addr == '0));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(upd_strobe)) |-> $stable(rd_addr));

  // R10
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stop && busy && (cfg_stop_mode == 2'd0 || cfg_stop_mode == 2'd3))
      |=> !upd_strobe);
endmodule

bind wave_update_ctrl wave_update_ctrl_chk #(
  .DEPTH(DEPTH), .MIN_INTERVAL(MIN_INTERVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_stop(sw_stop), .cfg_stop_mode(cfg_stop_mode),
  .upd_strobe(upd_strobe), .rd_addr(rd_addr), .wave_end(wave_end), .busy(busy)
);

// File: tb/test_wave_update_ctrl.sv
`timescale 1ns/1ps
module test_wave_update_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0, sw_start = 1'b0, sw_stop = 1'b0;
  logic [23:0] cfg_interval = 24'd40;
  logic [15:0] cfg_start_dly = '0, cfg_gap = '0, cfg_iter = 16'd1;
  logic        cfg_infinite = 1'b0, cfg_retrig = 1'b0, cfg_dual = 1'b0;
  logic [1:0]  cfg_stop_mode = 2'd0;
  logic [11:0] cfg_wave_len = 12'd4;
  logic        upd_strobe, wave_end, busy;
  logic [10:0] rd_addr;

  wave_update_ctrl i_wave_update_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sw_start(sw_start), .sw_stop(sw_stop),
    .cfg_interval(cfg_interval), .cfg_start_dly(cfg_start_dly), .cfg_gap(cfg_gap),
    .cfg_iter(cfg_iter), .cfg_infinite(cfg_infinite), .cfg_stop_mode(cfg_stop_mode),
    .cfg_retrig(cfg_retrig), .cfg_wave_len(cfg_wave_len), .cfg_dual(cfg_dual),
    .upd_strobe(upd_strobe), .rd_addr(rd_addr), .wave_end(wave_end), .busy(busy)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  int cyc = 0;
  int n_str, n_wend, addr_err, first_cyc, last_cyc, min_sp, max_sp, last_addr;
  int exp_addr, exp_len;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // monitor: samples outputs at the falling edge
  always @(negedge clk) begin
    if (upd_strobe) begin
      if (n_str == 0) first_cyc = cyc;
      else begin
        if (cyc - last_cyc < min_sp) min_sp = cyc - last_cyc;
        if (cyc - last_cyc > max_sp) max_sp = cyc - last_cyc;
      end
      last_cyc = cyc;
      if (int'(rd_addr) != exp_addr) addr_err++;
      if (wave_end != (exp_addr == exp_len - 1)) addr_err++;
      last_addr = int'(rd_addr);
      if (wave_end) n_wend++;
      exp_addr = (exp_addr == exp_len - 1) ? 0 : exp_addr + 1;
      n_str++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic clear_mon(input int len);
    n_str = 0; n_wend = 0; addr_err = 0; first_cyc = 0; last_cyc = 0;
    min_sp = 1 << 30; max_sp = 0; last_addr = -1; exp_addr = 0; exp_len = len;
  endtask

  task automatic setup(input int iv, input int len, input int iter, input bit inf,
                       input int mode, input bit rt, input int dly, input int gap,
                       input bit dual, input int elen);
    step();
    cfg_interval = 24'(iv); cfg_wave_len = 12'(len); cfg_iter = 16'(iter);
    cfg_infinite = inf; cfg_stop_mode = 2'(mode); cfg_retrig = rt;
    cfg_start_dly = 16'(dly); cfg_gap = 16'(gap); cfg_dual = dual;
    clear_mon(elen);
    step();
  endtask

  task automatic p_start(); step(); sw_start = 1; step(); sw_start = 0; endtask
  task automatic p_stop();  step(); sw_stop = 1;  step(); sw_stop = 0;  endtask
  task automatic p_trig();  step(); trig = 1; step(2); trig = 0; endtask

  task automatic wait_idle(input int lim);
    for (int k = 0; k < lim && busy; k++) step();
  endtask
  task automatic wait_str(input int n, input int lim);
    for (int k = 0; k < lim && n_str < n; k++) step();
  endtask
  task automatic wait_wend(input int n, input int lim);
    for (int k = 0; k < lim && n_wend < n; k++) step();
  endtask

  task automatic t_reset();
    check("R1 busy after reset", int'(busy), 0);
    check("R1 strobe after reset", int'(upd_strobe), 0);
    check("R1 rd_addr after reset", int'(rd_addr), 0);
  endtask

  task automatic t_arming();
    setup(40, 4, 1, 0, 0, 0, 0, 0, 0, 4);
    p_trig(); step(200);
    check("R2 trigger while idle strobes", n_str, 0);
    check("R2 trigger while idle busy", int'(busy), 0);
    p_start(); step(200);
    check("R2 armed no trigger strobes", n_str, 0);
    check("R2 armed busy", int'(busy), 1);
    p_stop(); step(3);
    check("R13 stop while armed busy", int'(busy), 0);
  endtask

  task automatic t_basic();
    setup(40, 4, 2, 0, 0, 0, 0, 0, 0, 4);
    p_start(); p_trig(); wait_idle(2000);
    check("R6 strobes for two passes", n_str, 8);
    check("R5 pass ends", n_wend, 2);
    check("R5 address order", addr_err, 0);
    check("R3 min spacing", min_sp, 40);
    check("R3 max spacing", max_sp, 40);
    check("R6 busy after finite run", int'(busy), 0);
  endtask

  task automatic t_delay();
    int t0, lat0, lat1;
    setup(40, 1, 1, 0, 0, 0, 0, 0, 0, 1);
    p_start(); step(); trig = 1; t0 = cyc; step(2); trig = 0;
    wait_idle(2000); lat0 = first_cyc - t0;
    setup(40, 1, 1, 0, 0, 0, 50, 0, 0, 1);
    p_start(); step(); trig = 1; t0 = cyc; step(2); trig = 0;
    wait_idle(2000); lat1 = first_cyc - t0;
    check("R4 start delay shift", lat1 - lat0, 50);
    setup(40, 4, 1, 0, 1, 0, 1000, 0, 0, 4);
    p_start(); p_trig(); step(20); p_stop(); step(3);
    check("R13 stop during delay busy", int'(busy), 0);
    step(1200);
    check("R13 stop during delay strobes", n_str, 0);
  endtask

  task automatic t_gap();
    setup(40, 2, 2, 0, 0, 0, 0, 30, 0, 2);
    p_start(); p_trig(); wait_idle(2000);
    check("R7 strobes with gap", n_str, 4);
    check("R7 spacing across gap", max_sp, 70);
    check("R7 spacing inside pass", min_sp, 40);
  endtask

  task automatic t_clamp();
    setup(5, 3, 1, 0, 0, 0, 0, 0, 0, 3);
    p_start(); p_trig(); wait_idle(2000);
    check("R3 short interval raised min", min_sp, 40);
    check("R3 short interval raised max", max_sp, 40);
    setup(40, 0, 1, 0, 0, 0, 0, 0, 0, 1);
    p_start(); p_trig(); wait_idle(2000);
    check("R5 zero length strobes", n_str, 1);
    check("R5 zero length pass end", n_wend, 1);
  endtask

  task automatic t_infinite();
    setup(40, 2, 2, 1, 0, 0, 0, 0, 0, 2);
    p_start(); p_trig(); wait_wend(6, 3000);
    check("R8 passes beyond count", int'(n_wend >= 6), 1);
    check("R8 still busy", int'(busy), 1);
    p_stop(); step(3);
    check("R10 busy after stop", int'(busy), 0);
  endtask

  task automatic t_stop_now();
    setup(40, 4, 1, 1, 0, 0, 0, 0, 0, 4);
    p_start(); p_trig(); wait_str(5, 2000);
    p_stop(); step(200);
    check("R10 strobes after immediate stop", n_str, 5);
    check("R10 busy after immediate stop", int'(busy), 0);
  endtask

  task automatic t_stop_pass();
    setup(40, 4, 1, 1, 1, 0, 0, 0, 0, 4);
    p_start(); p_trig(); wait_str(6, 2000);
    p_stop(); wait_idle(2000);
    check("R11 strobes to end of pass", n_str, 8);
    check("R11 last address", last_addr, 3);
    check("R11 address order", addr_err, 0);
  endtask

  task automatic t_stop_block();
    setup(40, 2, 3, 1, 2, 0, 0, 0, 0, 2);
    p_start(); p_trig(); wait_str(3, 2000);
    p_stop(); wait_idle(2000);
    check("R12 strobes to end of block", n_str, 6);
    check("R12 passes in block", n_wend, 3);
  endtask

  task automatic t_retrig();
    setup(40, 3, 1, 0, 0, 1, 0, 0, 0, 3);
    p_start(); p_trig(); wait_str(1, 2000);
    p_trig(); wait_wend(1, 2000); step(100);
    check("R9 trigger during run ignored", n_str, 3);
    check("R9 busy while re-armed", int'(busy), 1);
    p_trig(); wait_wend(2, 2000); step(50);
    check("R9 second generation strobes", n_str, 6);
    check("R9 restart from address 0", addr_err, 0);
    p_stop(); step(3);
    check("R13 stop while re-armed", int'(busy), 0);
  endtask

  task automatic t_dual();
    setup(40, 2048, 1, 0, 0, 0, 0, 0, 1, 1024);
    p_start(); p_trig(); wait_idle(60000);
    check("R5 dual length cap strobes", n_str, 1024);
    check("R5 dual last address", last_addr, 1023);
    check("R5 dual address order", addr_err, 0);
  endtask

  initial begin
    clear_mon(4);
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_arming();
    t_basic();
    t_delay();
    t_gap();
    t_clamp();
    t_infinite();
    t_stop_now();
    t_stop_pass();
    t_stop_block();
    t_retrig();
    t_dual();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule